// File: doc/BRIEF.md
# Tiled Aperture Fence Register Bank

This block keeps a bank of fence descriptors. Each descriptor marks one tiled window inside a linear graphics aperture. Each fence is a 64-bit value that software writes as two 32-bit halves through a plain register port. The low half holds the first page of the window, the pitch, the tiling mode and an enable bit. The high half holds the last page of the window. Reads return each half exactly as it was written, so software can confirm every step of an update.

A lookup port takes an aperture byte address. One cycle later it reports whether the address falls inside an enabled window. It also reports which fence matched, that fence's tiling mode, its pitch in bytes, and whether more than one enabled window covered the address. A new fence is programmed in three steps: clear the low half, write the high half, then write the low half. No lookup can therefore see a fence that is enabled but only half written.

Top module: `tile_fence_bank`

## Requirements
- R1: After a synchronous reset every stored half reads as zero, and no lookup hits.
- R2: `reg_addr` is {fence index, half}. Half 0 is the low word and half 1 is the high word. A write stores `reg_wdata` exactly. `reg_rdata` shows the word selected by `reg_addr` one clock edge after the address is presented.
- R3: Low word layout: bit 0 is the enable bit. Bit 1 is the Y-tiling flag. Bits [PITCH_LSB +: PITCH_W] hold (stride/128)−1. Bits [31:12] hold the first 4 KiB page. High word layout: bits [31:12] hold the last page of the window (start + size − 4 KiB).
- R4: A fence matches an address only while its enable bit is set and the address page lies between its first page and its last page, both inclusive. Disabled fences never match.
- R5: On a hit, `lk_ymode` is 1 for Y-tiling and 0 for X-tiling, taken from bit 1 of the fence that won.
- R6: On a hit, `lk_pitch` equals (pitch field + 1) × 128 bytes.
- R7: When several enabled fences match, the lowest-numbered one is reported. `lk_overlap` is 1 exactly when two or more enabled fences match.
- R8: Clearing the low word disables the fence from the next lookup on. A high-word write to a disabled fence does not enable it. The final low-word write enables the new window.
- R9: A lookup result appears on the cycle after `lk_req`, with `lk_rsp_valid` set. On a miss, or when no request was made, `lk_idx`, `lk_ymode`, `lk_pitch` and `lk_overlap` are zero.
- R10: NUM_FENCES selects 8, 16 or 32 fences. The index field width follows from it, and the highest-numbered fence is fully usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | IDX_W+1 | {fence index, half} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Aperture byte address to look up |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Address is inside an enabled fence |
| lk_idx | output | IDX_W | Winning fence number |
| lk_ymode | output | 1 | 1 = Y-tiling, 0 = X-tiling |
| lk_pitch | output | PITCH_W+8 | Pitch in bytes |
| lk_overlap | output | 1 | Two or more enabled fences matched |

## Verification
The hardest situation to reach is the middle of a three-step update. At that point a fence holds a new high word but a cleared low word, and it must stay invisible even though its page range would cover the probed address. The bench stops after each step of such an update on the highest-numbered fence and probes an address inside the new window, so it sees a miss, a miss, then a hit. Overlap priority is reached by programming deliberately overlapping windows. A page sweep then hits first pages, last pages and mid-page offsets, and compares each result with a model computed from the stored words.

// File: rtl/fbank_pkg.sv
package fbank_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned PG_W       = WORD_W - PAGE_SHIFT;
  localparam int unsigned VALID_BIT  = 0;
  localparam int unsigned YTILE_BIT  = 1;
  localparam int unsigned STRIDE_SH  = 7;

  typedef enum logic {
    TILE_X = 1'b0,
    TILE_Y = 1'b1
  } tile_mode_e;
endpackage

// File: rtl/fence_regfile.sv
module fence_regfile
  import fbank_pkg::*;
#(
  parameter int unsigned NUM_FENCES = 32,
  parameter int unsigned PITCH_LSB  = 2,
  parameter int unsigned PITCH_W    = 10,
  localparam int unsigned IDX_W     = $clog2(NUM_FENCES)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [IDX_W:0]                     addr,
  input  logic [WORD_W-1:0]                  wdata,
  output logic [WORD_W-1:0]                  rdata,
  output logic [NUM_FENCES-1:0]              f_vld,
  output logic [NUM_FENCES-1:0]              f_ytile,
  output logic [NUM_FENCES-1:0][PITCH_W-1:0] f_pitch,
  output logic [NUM_FENCES-1:0][PG_W-1:0]    f_first,
  output logic [NUM_FENCES-1:0][PG_W-1:0]    f_last
);
  logic [WORD_W-1:0] lo_mem [NUM_FENCES];
  logic [WORD_W-1:0] hi_mem [NUM_FENCES];
  logic [IDX_W-1:0]  sel_idx;
  logic              sel_hi;

  assign sel_idx = addr[IDX_W:1];
  assign sel_hi  = addr[0];

  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_fence
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_mem[g] <= '0;
        hi_mem[g] <= '0;
      end else if (we && sel_idx == IDX_W'(g)) begin
        if (sel_hi) hi_mem[g] <= wdata;
        else        lo_mem[g] <= wdata;
      end
    end

    assign f_vld[g]   = lo_mem[g][VALID_BIT];
    assign f_ytile[g] = lo_mem[g][YTILE_BIT];
    assign f_pitch[g] = lo_mem[g][PITCH_LSB +: PITCH_W];
    assign f_first[g] = lo_mem[g][WORD_W-1:PAGE_SHIFT];
    assign f_last[g]  = hi_mem[g][WORD_W-1:PAGE_SHIFT];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel_hi ? hi_mem[sel_idx] : lo_mem[sel_idx];
  end
endmodule

// File: rtl/fence_match.sv
module fence_match
  import fbank_pkg::*;
#(
  parameter int unsigned NUM_FENCES = 32
) (
  input  logic [WORD_W-1:0]               addr,
  input  logic [NUM_FENCES-1:0]           f_vld,
  input  logic [NUM_FENCES-1:0][PG_W-1:0] f_first,
  input  logic [NUM_FENCES-1:0][PG_W-1:0] f_last,
  output logic [NUM_FENCES-1:0]           match
);
  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_cmp
    logic [WORD_W-1:0] lo_bound;
    logic [WORD_W-1:0] hi_bound;
    assign lo_bound = {f_first[g], {PAGE_SHIFT{1'b0}}};
    assign hi_bound = {f_last[g],  {PAGE_SHIFT{1'b1}}};
    assign match[g] = f_vld[g] && (addr >= lo_bound) && (addr <= hi_bound);
  end
endmodule

// File: rtl/fence_select.sv
module fence_select #(
  parameter int unsigned NUM_FENCES = 32,
  localparam int unsigned IDX_W     = $clog2(NUM_FENCES)
) (
  input  logic [NUM_FENCES-1:0] match,
  output logic                  any,
  output logic [IDX_W-1:0]      idx,
  output logic                  multi
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_FENCES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign multi = |(match & (match - NUM_FENCES'(1)));
endmodule

// File: rtl/tile_fence_bank.sv
module tile_fence_bank
  import fbank_pkg::*;
#(
  parameter int unsigned NUM_FENCES = 32,
  parameter int unsigned PITCH_LSB  = 2,
  parameter int unsigned PITCH_W    = 10,
  localparam int unsigned IDX_W     = $clog2(NUM_FENCES),
  localparam int unsigned PB_W      = PITCH_W + 1 + STRIDE_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [IDX_W:0]    reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_req,
  input  logic [31:0]       lk_addr,
  output logic              lk_rsp_valid,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              lk_ymode,
  output logic [PB_W-1:0]   lk_pitch,
  output logic              lk_overlap
);
  logic [NUM_FENCES-1:0]              f_vld;
  logic [NUM_FENCES-1:0]              f_ytile;
  logic [NUM_FENCES-1:0][PITCH_W-1:0] f_pitch;
  logic [NUM_FENCES-1:0][PG_W-1:0]    f_first;
  logic [NUM_FENCES-1:0][PG_W-1:0]    f_last;
  logic [NUM_FENCES-1:0]              match;
  logic                               any;
  logic [IDX_W-1:0]                   win;
  logic                               multi;
  logic [PITCH_W:0]                   units;
  logic [PB_W-1:0]                    bytes_nxt;
  tile_mode_e                         mode_nxt;

  fence_regfile #(
    .NUM_FENCES(NUM_FENCES), .PITCH_LSB(PITCH_LSB), .PITCH_W(PITCH_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .f_vld(f_vld), .f_ytile(f_ytile), .f_pitch(f_pitch),
    .f_first(f_first), .f_last(f_last)
  );

  fence_match #(.NUM_FENCES(NUM_FENCES)) u_match (
    .addr(lk_addr), .f_vld(f_vld), .f_first(f_first), .f_last(f_last),
    .match(match)
  );

  fence_select #(.NUM_FENCES(NUM_FENCES)) u_sel (
    .match(match), .any(any), .idx(win), .multi(multi)
  );

  assign units     = {1'b0, f_pitch[win]} + {{PITCH_W{1'b0}}, 1'b1};
  assign bytes_nxt = {units, {STRIDE_SH{1'b0}}};
  assign mode_nxt  = f_ytile[win] ? TILE_Y : TILE_X;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_rsp_valid <= 1'b0;
      lk_hit       <= 1'b0;
      lk_idx       <= '0;
      lk_ymode     <= 1'b0;
      lk_pitch     <= '0;
      lk_overlap   <= 1'b0;
    end else begin
      lk_rsp_valid <= lk_req;
      lk_hit       <= lk_req && any;
      lk_idx       <= (lk_req && any) ? win : '0;
      lk_ymode     <= lk_req && any && (mode_nxt == TILE_Y);
      lk_pitch     <= (lk_req && any) ? bytes_nxt : '0;
      lk_overlap   <= lk_req && multi;
    end
  end
endmodule

// File: rtl/fence_bank_chk.sv
module fence_bank_chk #(
  parameter int unsigned NUM_FENCES = 32,
  parameter int unsigned PB_W       = 18,
  localparam int unsigned IDX_W     = $clog2(NUM_FENCES)
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [IDX_W:0]   reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             lk_req,
  input logic             lk_rsp_valid,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx,
  input logic [PB_W-1:0]  lk_pitch,
  input logic             lk_overlap
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!lk_hit && reg_rdata == 32'd0)); // R1

  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    (reg_we ##1 (!reg_we && reg_addr == $past(reg_addr))) |=> (reg_rdata == $past(reg_wdata, 2))); // R2

  AST_PITCH_GRAIN: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_pitch[6:0] == 7'd0 && lk_pitch != '0)); // R6

  AST_OVERLAP_HIT: assert property (@(posedge clk) disable iff (rst)
    lk_overlap |-> lk_hit); // R7

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (lk_rsp_valid == $past(lk_req))); // R9

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_idx == '0 && lk_pitch == '0)); // R9
endmodule

bind tile_fence_bank fence_bank_chk #(.NUM_FENCES(NUM_FENCES), .PB_W(PB_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
  .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_idx(lk_idx),
  .lk_pitch(lk_pitch), .lk_overlap(lk_overlap)
);

// File: tb/tile_fence_bank_tb.sv
module tile_fence_bank_tb;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int PW = 10;
  localparam int BW = PW + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [IW:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic lk_rsp_valid, lk_hit, lk_ymode, lk_overlap;
  logic [IW-1:0] lk_idx;
  logic [BW-1:0] lk_pitch;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];

  always #4 clk = ~clk;

  tile_fence_bank #(.NUM_FENCES(N), .PITCH_LSB(2), .PITCH_W(PW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req),
    .lk_addr(lk_addr), .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_ymode(lk_ymode), .lk_pitch(lk_pitch),
    .lk_overlap(lk_overlap)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {IW'(idx), hi}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (hi) m_hi[idx] = d; else m_lo[idx] = d;
  endtask

  task automatic rd(input int idx, input bit hi, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = {IW'(idx), hi};
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_lo(input int first_pg, input bit y, input int stride, input bit en);
    return (32'(first_pg) << 12) | (32'(stride / 128 - 1) << 2) | (32'(y) << 1) | 32'(en);
  endfunction

  // packs {valid, hit, idx, y, pitch, overlap}
  function automatic logic [63:0] model(input logic [31:0] a);
    int cnt = 0;
    int win = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_lo[i][0] && a[31:12] >= m_lo[i][31:12] && a[31:12] <= m_hi[i][31:12]) begin
        cnt++; win = i;
      end
    end
    if (cnt == 0) return {40'd0, 1'b1, 1'b0, 3'd0, 1'b0, 18'd0, 1'b0};
    return {40'd0, 1'b1, 1'b1, 3'(win), m_lo[win][1],
            18'((32'(m_lo[win][11:2]) + 1) * 128), 1'(cnt > 1)};
  endfunction

  task automatic look(input string req, input logic [31:0] a);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    check(req, {40'd0, lk_rsp_valid, lk_hit, lk_idx, lk_ymode, lk_pitch, lk_overlap}, model(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int i = 0; i < 2 * N; i++) begin
      rd(i / 2, 1'(i % 2), d);
      check("R1 reset readback", 64'(d), 64'd0);
    end
    look("R1 reset lookup", 32'h0000_0000);
    look("R1 reset lookup", 32'h0123_4567);

    // R9: no request -> nothing reported
    @(negedge clk);
    @(negedge clk);
    check("R9 idle", {63'd0, lk_rsp_valid | lk_hit}, 64'd0);

    // R2 / R10: raw readback over every half, including the top fence
    for (int i = 0; i < 2 * N; i++) wr(i / 2, 1'(i % 2), 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0107));
    for (int i = 0; i < 2 * N; i++) begin
      rd(i / 2, 1'(i % 2), d);
      check((i >= 2 * N - 2) ? "R10 top fence readback" : "R2 readback", 64'(d),
            64'(32'hA5C3_0000 ^ (32'(i) * 32'h0101_0107)));
    end
    wr(3, 1'b0, 32'h0000_0000);
    rd(3, 1'b0, d);
    check("R2 readback zero", 64'(d), 64'd0);
    for (int i = 0; i < 2 * N; i++) wr(i / 2, 1'(i % 2), 32'd0);

    // R3: program windows using the field layout
    wr(0, 1'b1, 32'(7) << 12);  wr(0, 1'b0, mk_lo(4, 1'b0, 512, 1'b1));
    wr(1, 1'b1, 32'(10) << 12); wr(1, 1'b0, mk_lo(10, 1'b1, 128, 1'b1));
    wr(2, 1'b1, 32'(12) << 12); wr(2, 1'b0, mk_lo(6, 1'b1, 1024, 1'b1));
    wr(3, 1'b1, 32'(30) << 12); wr(3, 1'b0, mk_lo(20, 1'b0, 256, 1'b0));
    wr(5, 1'b1, 32'(50) << 12); wr(5, 1'b0, mk_lo(40, 1'b0, 131072, 1'b1));
    wr(7, 1'b1, 32'(63) << 12); wr(7, 1'b0, mk_lo(60, 1'b1, 2048, 1'b1));

    // R4 R5 R6 R7: page sweep with first, last and mid offsets
    for (int p = 0; p < 72; p++) begin
      logic [31:0] off;
      off = (p % 3 == 0) ? 32'h000 : (p % 3 == 1) ? 32'hFFF : 32'((p * 37) % 4096);
      look("R4 R5 R6 R7 sweep", (32'(p) << 12) | off);
    end
    look("R4 disabled fence ignored", 32'h0001_8800);
    look("R7 overlap lowest wins", 32'h0000_6000);
    look("R7 overlap at shared page", 32'h0000_A010);
    look("R6 max pitch", 32'h0002_D000);

    // R8: three-step update of the top fence, probed after each step
    wr(7, 1'b0, 32'd0);
    look("R8 cleared low misses", 32'h0003_D000);
    wr(7, 1'b1, 32'(66) << 12);
    look("R8 high only stays off", 32'h0004_1000);
    check("R8 expect miss", {63'd0, lk_hit}, 64'd0);
    wr(7, 1'b0, mk_lo(64, 1'b0, 384 + 128, 1'b1));
    look("R8 final low enables", 32'h0004_1000);
    check("R8 expect hit idx7", {60'd0, lk_hit, lk_idx}, {60'd0, 1'b1, 3'd7});
    look("R8 old window gone", 32'h0003_C000);

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    rd(0, 1'b0, d);
    check("R1 reset clears fence0", 64'(d), 64'd0);
    look("R1 after reset miss", 32'h0000_5000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule